// File: doc/BRIEF.md
# Frequency Count to MHz Text Formatter

This block turns a 32-bit frequency count, given in hertz, into a line of readable text. A one-cycle start pulse captures the count. The block then divides the value by ten over and over, using a bit-serial divider that it contains, and keeps each remainder as one decimal digit. When the quotient reaches zero, the block sends the digits as ASCII bytes over a valid/ready byte stream, most significant digit first.

A decimal point goes after the millions digit, so the value reads in megahertz. Then follow a space, the unit letters and a carriage return. Leading zeros never appear. A count too short to reach the millions digit is printed without any point. A busy flag covers the whole job, and a new start pulse is accepted only once the line has been fully sent.

Top module: `mhz_text_fmt`

## Requirements
- R1: The count is reduced by repeated division by ten until the quotient is zero. Each remainder r becomes one stored digit with character code 0x30+r. Up to ten digits are held, which covers every 32-bit count.
- R2: The digits go out most significant first. Only the digits that were produced are sent, so the line has no leading zero.
- R3: A count of zero produces exactly one digit, '0' (0x30), followed by the suffix.
- R4: A '.' (0x2E) is sent right after the digit that has exactly six digits below it. A count with fewer than seven digits gets no '.'.
- R5: After the last digit come five bytes in this order: 0x20, 0x4D, 0x68, 0x7A and 0x0D (space, 'M', 'h', 'z', carriage return).
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change. A byte counts as accepted only on a clock edge where both are high.
- R7: busy_o rises on the clock edge that samples start_i high while the block is idle. It stays high until the edge that accepts the carriage return. A start_i pulse while busy_o is high is ignored and does not change the line being sent.
- R8: While reset is held, and right after it, busy_o and out_valid_o are low.
- R9: The largest count, 4294967295, is sent as "4294.967295 Mhz" followed by a carriage return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse, sampled while idle |
| count_i | input | 32 | Frequency count in Hz, captured with start_i |
| busy_o | output | 1 | High from the accepted start until the carriage return is accepted |
| out_valid_o | output | 1 | A text byte is available |
| out_data_o | output | 8 | ASCII text byte |
| out_ready_i | input | 1 | The sink accepts the byte on this edge |

## Verification
The assertions assume that the sink may hold out_ready_i low for any number of cycles, but that it never needs the byte to change while waiting. They also assume that count_i matters only on the cycle in which start_i is sampled while idle. The stimulus drives the ready line from a pseudo-random pattern, so bytes are accepted sometimes back to back and sometimes after stalls. It pulses start_i again in the middle of one line with a different count, to show that the repeated pulse is ignored. The counts chosen cover zero, a single digit, a value just under and just over the point threshold, and the largest 32-bit value.

// File: rtl/mhz_fmt_pkg.sv
package mhz_fmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GO,
    ST_WAIT,
    ST_DIG,
    ST_DOT,
    ST_SFX
  } fmt_state_e;

  localparam int unsigned SFX_LEN = 5;

  function automatic logic [7:0] sfx_char(input logic [2:0] k);
    case (k)
      3'd0:    sfx_char = 8'h20;
      3'd1:    sfx_char = 8'h4D;
      3'd2:    sfx_char = 8'h68;
      3'd3:    sfx_char = 8'h7A;
      default: sfx_char = 8'h0D;
    endcase
  endfunction

endpackage

// File: rtl/mhz_div10_seq.sv
module mhz_div10_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [3:0]   rem
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_n, quo_q, quo_n;
  logic [3:0]    rem_q, rem_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n, done_q, done_n;
  logic [4:0]    trial;
  logic          ge;

  assign trial = {rem_q, sh_q[W-1]};
  assign ge    = (trial >= 5'd10);

  always_comb begin
    sh_n   = sh_q;
    quo_n  = quo_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (go) begin
      sh_n  = dvd;
      quo_n = '0;
      rem_n = '0;
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      rem_n = ge ? 4'(trial - 5'd10) : trial[3:0];
      quo_n = {quo_q[W-2:0], ge};
      sh_n  = {sh_q[W-2:0], 1'b0};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign quot = quo_q;
  assign rem  = rem_q;

  // R1: the partial remainder never leaves the decimal digit range
  a_r1_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < 4'd10));

  // R1: done is a single-cycle pulse
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/mhz_digit_buf.sv
module mhz_digit_buf #(
  parameter int DEPTH = 10,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_dig,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_char
);
  logic [3:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[i] <= '0;
      else if (cell_en) cell_q[i] <= wr_dig;
    end
  end

  always_comb begin
    rd_char = 8'h30;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == AW'(i)) rd_char = 8'h30 + {4'h0, cell_q[i]};
    end
  end

  // R1: only digit values are written
  a_r1_wr_digit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_dig < 4'd10) && (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/mhz_text_fmt.sv
module mhz_text_fmt #(
  parameter int CNT_W      = 32,
  parameter int MAX_DIGITS = 10,
  parameter int POINT_POS  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i
);
  import mhz_fmt_pkg::*;

  localparam int NW = $clog2(MAX_DIGITS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rs_a_q, rs_b_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a_q <= 1'b0;
      rs_b_q <= 1'b0;
    end else begin
      rs_a_q <= 1'b1;
      rs_b_q <= rs_a_q;
    end
  end
  logic arst_n;
  assign arst_n = rs_b_q;

  fmt_state_e       st_q, st_n;
  logic [CNT_W-1:0] work_q, work_n;
  logic [NW-1:0]    ndig_q, ndig_n, idx_q, idx_n;
  logic [2:0]       sidx_q, sidx_n;

  logic             div_go, div_done;
  logic [CNT_W-1:0] div_quot;
  logic [3:0]       div_rem;
  logic             buf_we;
  logic [7:0]       dig_char;
  logic             xfer;

  mhz_div10_seq #(.W(CNT_W)) i_div (
    .clk  (clk),
    .rst_n(arst_n),
    .go   (div_go),
    .dvd  (work_q),
    .done (div_done),
    .quot (div_quot),
    .rem  (div_rem)
  );

  mhz_digit_buf #(.DEPTH(MAX_DIGITS), .AW(NW)) i_buf (
    .clk    (clk),
    .rst_n  (arst_n),
    .wr_en  (buf_we),
    .wr_addr(ndig_q),
    .wr_dig (div_rem),
    .rd_addr(idx_q),
    .rd_char(dig_char)
  );

  assign div_go      = (st_q == ST_GO);
  assign buf_we      = (st_q == ST_WAIT) && div_done;
  assign out_valid_o = (st_q == ST_DIG) || (st_q == ST_DOT) || (st_q == ST_SFX);
  assign busy_o      = (st_q != ST_IDLE);
  assign xfer        = out_valid_o && out_ready_i;

  always_comb begin
    case (st_q)
      ST_DIG:  out_data_o = dig_char;
      ST_DOT:  out_data_o = 8'h2E;
      ST_SFX:  out_data_o = sfx_char(sidx_q);
      default: out_data_o = 8'h00;
    endcase
  end

  always_comb begin
    st_n   = st_q;
    work_n = work_q;
    ndig_n = ndig_q;
    idx_n  = idx_q;
    sidx_n = sidx_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        work_n = count_i;
        ndig_n = '0;
        st_n   = ST_GO;
      end
      ST_GO: st_n = ST_WAIT;
      ST_WAIT: if (div_done) begin
        work_n = div_quot;
        ndig_n = ndig_q + 1'b1;
        if (div_quot == '0) begin
          idx_n = ndig_q;
          st_n  = ST_DIG;
        end else begin
          st_n = ST_GO;
        end
      end
      ST_DIG: if (xfer) begin
        if (idx_q == NW'(POINT_POS)) begin
          st_n = ST_DOT;
        end else if (idx_q == '0) begin
          sidx_n = '0;
          st_n   = ST_SFX;
        end else begin
          idx_n = idx_q - 1'b1;
        end
      end
      ST_DOT: if (xfer) begin
        idx_n = idx_q - 1'b1;
        st_n  = ST_DIG;
      end
      ST_SFX: if (xfer) begin
        if (sidx_q == 3'(SFX_LEN - 1)) st_n = ST_IDLE;
        else                           sidx_n = sidx_q + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_IDLE;
      work_q <= '0;
      ndig_q <= '0;
      idx_q  <= '0;
      sidx_q <= '0;
    end else begin
      st_q   <= st_n;
      work_q <= work_n;
      ndig_q <= ndig_n;
      idx_q  <= idx_n;
      sidx_q <= sidx_n;
    end
  end

  // R1: each divider result reconstructs the value it was given
  a_r1_div_exact: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_WAIT && div_done) |->
      ({4'h0, div_quot} * 36'd10 + {32'h0, div_rem} == {4'h0, work_q}));

  // R1: the digit count never exceeds the buffer depth
  a_r1_depth: assert property (@(posedge clk) disable iff (!arst_n)
    int'(ndig_q) <= MAX_DIGITS);

  // R2: only stored digits are read out
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_DIG) |-> (idx_q < ndig_q));

  // R4: a point appears only for numbers that reach the millions digit
  a_r4_point_len: assert property (@(posedge clk) disable iff (!arst_n)
    (out_valid_o && out_data_o == 8'h2E) |-> (int'(ndig_q) > POINT_POS));

  // R6: a stalled byte is held
  a_r6_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R7: busy ends only on acceptance of the carriage return
  a_r7_busy_end: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(busy_o) |-> $past(xfer && out_data_o == 8'h0D));

endmodule

// File: tb/test_mhz_text_fmt.sv
module test_mhz_text_fmt;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] count_i;
  logic        busy_o;
  logic        out_valid_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done_flag = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] lfsr = 8'hA5;
  bit         ready_always = 0;
  bit         hold_pend = 0;
  logic [7:0] hold_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mhz_text_fmt i_mhz_text_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .count_i    (count_i),
    .busy_o     (busy_o),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_ready_i(out_ready_i)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // expected line from the requirements: R1, R2, R4, R5
  task automatic push_line(input logic [31:0] v, input string tag);
    logic [7:0] d[$];
    longint x = longint'(v);
    do begin
      d.push_back(8'h30 + 8'(x % 10));
      x = x / 10;
    end while (x != 0);
    for (int p = d.size() - 1; p >= 0; p--) begin
      exp_q.push_back(d[p]); tag_q.push_back(tag);
      if (p == 6) begin exp_q.push_back(8'h2E); tag_q.push_back("R4"); end
    end
    exp_q.push_back(8'h20); tag_q.push_back("R5");
    exp_q.push_back(8'h4D); tag_q.push_back("R5");
    exp_q.push_back(8'h68); tag_q.push_back("R5");
    exp_q.push_back(8'h7A); tag_q.push_back("R5");
    exp_q.push_back(8'h0D); tag_q.push_back("R5");
  endtask

  task automatic run(input logic [31:0] v, input string tag, input bit restart);
    push_line(v, tag);
    @(negedge clk);
    count_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; count_i = 32'h0;
    check(busy_o === 1'b1, "R7 busy rise", busy_o, 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      count_i = ~v; start_i = 1'b1;   // R7: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy_o === 1'b0, "R7 busy end", busy_o, 0);
    check(out_valid_o === 1'b0, "R7 idle valid", out_valid_o, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic rdy;
    if (rst_n === 1'b1 && !done_flag) begin
      if (hold_pend) begin
        check(out_valid_o === 1'b1 && out_data_o === hold_data, "R6 hold",
              {out_valid_o, out_data_o}, {1'b1, hold_data});
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy  = ready_always | lfsr[0] | lfsr[2];
      out_ready_i = rdy;
      hold_pend = 0;
      if (out_valid_o === 1'b1) begin
        if (rdy) begin
          if (exp_q.size() == 0) begin
            check(0, "R7 unexpected byte", out_data_o, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data_o === e, t, out_data_o, e);
          end
        end else begin
          hold_pend = 1;
          hold_data = out_data_o;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; count_i = '0; out_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0, "R8 busy reset", busy_o, 0);
    check(out_valid_o === 1'b0, "R8 valid reset", out_valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o === 1'b0 && out_valid_o === 1'b0, "R8 after reset",
          {busy_o, out_valid_o}, 0);
    run(32'd0,          "R3", 0);
    run(32'd7,          "R1", 0);
    run(32'd10,         "R2", 0);
    run(32'd123456,     "R4", 0);
    run(32'd1000000,    "R4", 0);
    run(32'd9999999,    "R2", 0);
    run(32'd1234567,    "R7", 1);
    run(32'hFFFFFFFF,   "R9", 0);
    ready_always = 1;
    run(32'd3000000000, "R1", 0);
    run(32'd50,         "R6", 0);
    done_flag = 1;
    summary();
  end

endmodule